// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small CPU and decides which peripheral interrupt the CPU should service next. Each source drives a one-cycle request pulse. The controller keeps a sticky pending flag, an enable bit and a 3-bit priority for each source. Every cycle it finds the highest-priority source that is pending and enabled. Ties are broken in favour of the lowest source number. The winner is then compared against the current CPU priority level.

When a request is accepted, the controller raises the CPU level to the winner's priority. It issues a one-cycle `irq_valid_o` pulse together with the vector number and the new level, and records both in a status word that a shared handler can read. The CPU level has three writable bits and a fourth bit that mirrors the trap input and cannot be written. A global control bit can forbid nesting: while it is set, nothing is accepted as long as the level is non-zero.

Software reaches all state through a word-addressed write port and a read port with one cycle of latency.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request pulse on source i sets its pending flag, which stays set until software writes a 1 to that bit. Flags live at word address 0x08 plus i/16, bit i%16. Writing a 0 to a flag bit leaves it unchanged.
- R2: Each source has an enable bit at word address 0x10 plus i/16, bit i%16. A pending source whose enable bit is clear is never presented.
- R3: Each source has a 3-bit priority at word address 0x18 plus i/4, bits [4*(i%4)+2 : 4*(i%4)]. A source with priority 0 is never accepted.
- R4: A source is eligible when it is pending, enabled, and its priority is strictly greater than the 4-bit effective level (trap bit over the three writable level bits). The eligible source with the highest priority wins.
- R5: Among eligible sources with equal priority, the lowest source number wins.
- R6: On acceptance, the following take effect two clock edges after the request pulse:
  - `irq_valid_o` is high for exactly one cycle.
  - `irq_vec_o` carries the winning source number.
  - `irq_lvl_o` carries the winning priority.
  - The writable level bits take the winning priority.
  - A software write to the level register in the same cycle takes precedence and suppresses acceptance for that cycle.
- R7: The status word at address 0x02 holds the last accepted vector in bits [7:0] and the level it was accepted at in bits [11:8].
- R8: The level register at address 0x01 reads the three writable bits in [2:0] and the trap input in bit 3. Bit 3 cannot be written. While the trap input is high, no source is accepted.
- R9: Bit 0 of the control word at address 0x00 disables nesting. While it is 1 and the effective level is non-zero, no source is accepted. Acceptance resumes once software lowers the level to 0.
- R10: If a request pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R11: After a synchronous reset, the following all read zero and `irq_valid_o` is low:
  - every flag, enable and priority;
  - the level;
  - the control word;
  - the status word.
  
  Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | NSRC | Per-source request pulses |
| trap_i | input | 1 | Trap activity; forms the read-only upper level bit |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address for read and write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, one cycle after the address |
| irq_valid_o | output | 1 | One-cycle pulse when a request is accepted |
| irq_vec_o | output | log2(NSRC) | Accepted vector number |
| irq_lvl_o | output | 4 | New CPU level of the accepted request |

## Verification
The hardest state to reach from the ports is a flag that receives a request pulse and a software clear in the very same cycle. The bench reaches it by driving the pulse and the clear write in one shared cycle, with enables off so no acceptance disturbs the flag. It then reads the flag word back. Two other states are hard to stage: a blocked request that waits behind the trap bit or behind the nesting lock. For each, the bench pends the request while the block is in force, shows that no pulse appears, then releases the condition and observes the delayed acceptance.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int AW  = 5;   // register word address width
  localparam int PW  = 3;   // priority field width
  localparam int LW  = 4;   // effective CPU level width (trap bit + PW)
  localparam int NIB = 4;   // bits reserved per priority slot in a word

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_LVL  = 5'd1;
  localparam logic [AW-1:0] A_STAT = 5'd2;
  localparam logic [AW-1:0] A_FLAG = 5'd8;
  localparam logic [AW-1:0] A_EN   = 5'd16;
  localparam logic [AW-1:0] A_PRI  = 5'd24;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    set_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NSRC-1:0]    flag_o,
  output logic [NSRC-1:0]    en_o,
  output logic [NSRC*PW-1:0] prio_o
);
  localparam int PPW = DW / NIB;  // priority slots per word

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int WRD = g / DW;
    localparam int BIT = g % DW;
    localparam int PWD = g / PPW;
    localparam int PNB = g % PPW;
    localparam logic [AW-1:0] FA = A_FLAG + AW'(WRD);
    localparam logic [AW-1:0] EA = A_EN   + AW'(WRD);
    localparam logic [AW-1:0] PA = A_PRI  + AW'(PWD);

    logic          flag_r;
    logic          en_r;
    logic [PW-1:0] prio_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_r <= 1'b0;
        en_r   <= 1'b0;
        prio_r <= '0;
      end else begin
        // request pulse dominates a same-cycle clear
        if (set_i[g])
          flag_r <= 1'b1;
        else if (we_i && addr_i == FA && wdata_i[BIT])
          flag_r <= 1'b0;
        if (we_i && addr_i == EA)
          en_r <= wdata_i[BIT];
        if (we_i && addr_i == PA)
          prio_r <= wdata_i[PNB*NIB +: PW];
      end
    end

    assign flag_o[g]            = flag_r;
    assign en_o[g]              = en_r;
    assign prio_o[g*PW +: PW]   = prio_r;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int VW   = 4
) (
  input  logic [NSRC-1:0]    flag_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [LW-1:0]      cur_lvl_i,
  output logic               found_o,
  output logic [VW-1:0]      win_idx_o,
  output logic [PW-1:0]      win_prio_o
);
  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    // scan from the top so that an equal priority at a lower index replaces
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flag_i[i] && en_i[i] &&
          ({1'b0, prio_i[i*PW +: PW]} > cur_lvl_i) &&
          (!found_o || prio_i[i*PW +: PW] >= win_prio_o)) begin
        found_o    = 1'b1;
        win_prio_o = prio_i[i*PW +: PW];
        win_idx_o  = VW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter  int NSRC = 16,
  parameter  int DW   = 16,
  localparam int VW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pulse_i,
  input  logic            trap_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_valid_o,
  output logic [VW-1:0]   irq_vec_o,
  output logic [LW-1:0]   irq_lvl_o
);
  localparam int PPW = DW / NIB;

  logic [NSRC-1:0]    flag_q;
  logic [NSRC-1:0]    en_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [PW-1:0]      lvl_q;
  logic               nest_q;
  logic [VW-1:0]      stat_vec_q;
  logic [LW-1:0]      stat_lvl_q;

  logic               found;
  logic [VW-1:0]      win_idx;
  logic [PW-1:0]      win_prio;
  logic [LW-1:0]      cur_lvl;
  logic               lvl_we;
  logic               accept;
  logic [DW-1:0]      rd_word;

  irq_src_bank #(.NSRC(NSRC), .DW(DW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_pulse_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_o  (flag_q),
    .en_o    (en_q),
    .prio_o  (prio_q)
  );

  assign cur_lvl = {trap_i, lvl_q};

  irq_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
    .flag_i     (flag_q),
    .en_i       (en_q),
    .prio_i     (prio_q),
    .cur_lvl_i  (cur_lvl),
    .found_o    (found),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  assign lvl_we = we_i && (addr_i == A_LVL);
  assign accept = found && !lvl_we && !(nest_q && (cur_lvl != '0));

  always_comb begin
    rd_word = '0;
    if (addr_i == A_CTRL) rd_word[0] = nest_q;
    if (addr_i == A_LVL)  rd_word[LW-1:0] = cur_lvl;
    if (addr_i == A_STAT) begin
      rd_word[7:0]  = 8'(stat_vec_q);
      rd_word[11:8] = stat_lvl_q;
    end
    for (int i = 0; i < NSRC; i++) begin
      if (addr_i == A_FLAG + AW'(i / DW)) rd_word[i % DW] = flag_q[i];
      if (addr_i == A_EN   + AW'(i / DW)) rd_word[i % DW] = en_q[i];
      if (addr_i == A_PRI  + AW'(i / PPW))
        rd_word[(i % PPW)*NIB +: PW] = prio_q[i*PW +: PW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q       <= '0;
      nest_q      <= 1'b0;
      stat_vec_q  <= '0;
      stat_lvl_q  <= '0;
      irq_valid_o <= 1'b0;
      irq_vec_o   <= '0;
      irq_lvl_o   <= '0;
      rdata_o     <= '0;
    end else begin
      irq_valid_o <= accept;
      rdata_o     <= rd_word;
      if (we_i && addr_i == A_CTRL)
        nest_q <= wdata_i[0];
      if (lvl_we)
        lvl_q <= wdata_i[PW-1:0];
      else if (accept)
        lvl_q <= win_prio;
      if (accept) begin
        stat_vec_q <= win_idx;
        stat_lvl_q <= {1'b0, win_prio};
        irq_vec_o  <= win_idx;
        irq_lvl_o  <= {1'b0, win_prio};
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int VW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_pulse_i,
  input logic            trap_i,
  input logic            irq_valid_o,
  input logic [VW-1:0]   irq_vec_o,
  input logic [LW-1:0]   irq_lvl_o,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q,
  input logic [PW-1:0]   lvl_q,
  input logic            nest_q
);
  logic [NSRC-1:0] ok_q;

  always_ff @(posedge clk) begin
    if (rst) ok_q <= '0;
    else     ok_q <= flag_q & en_q;
  end

  // R2: presented vector was pending and enabled in the accepting cycle
  a_r2_only_enabled: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> ok_q[irq_vec_o]);

  // R4: accepted level exceeds the effective level seen when accepting
  a_r4_above_level: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_lvl_o > $past({trap_i, lvl_q})));

  // R6: level register follows the presented level
  a_r6_lvl_raised: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> ({1'b0, lvl_q} == irq_lvl_o));

  // R8: nothing is accepted while the trap bit is up
  a_r8_trap_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !$past(trap_i));

  // R9: nesting lock holds off acceptance at a non-zero level
  a_r9_nest_lock: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !$past(nest_q && ({trap_i, lvl_q} != '0)));

  // R10: every pulsed source is flagged on the following cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flag_q & $past(src_pulse_i)) == $past(src_pulse_i)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_pulse_i (src_pulse_i),
  .trap_i      (trap_i),
  .irq_valid_o (irq_valid_o),
  .irq_vec_o   (irq_vec_o),
  .irq_lvl_o   (irq_lvl_o),
  .flag_q      (flag_q),
  .en_q        (en_q),
  .lvl_q       (lvl_q),
  .nest_q      (nest_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  import irq_prio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_pulse_i = '0;
  logic        trap_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_valid_o;
  logic [3:0]  irq_vec_o;
  logic [3:0]  irq_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  int seen = 0;
  int last_vec = 0;
  int last_lvl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk (clk), .rst (rst), .src_pulse_i (src_pulse_i), .trap_i (trap_i),
    .we_i (we_i), .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
    .irq_valid_o (irq_valid_o), .irq_vec_o (irq_vec_o), .irq_lvl_o (irq_lvl_o)
  );

  always @(negedge clk) begin
    if (!rst && irq_valid_o) begin
      seen++;
      last_vec = int'(irq_vec_o);
      last_lvl = int'(irq_lvl_o);
    end
  end

  // {enable[15:0], set[15:0], level[2:0], valid, vector[3:0], new level[2:0]}
  // priority of source i is i>>1
  localparam logic [42:0] TBL [0:11] = '{
    {16'hFFFF, 16'h0004, 3'd0, 1'b1, 4'd2,  3'd1},  // R4 single
    {16'hFFFF, 16'h000C, 3'd0, 1'b1, 4'd2,  3'd1},  // R5 tie
    {16'hFFFF, 16'h8004, 3'd0, 1'b1, 4'd15, 3'd7},  // R4 highest
    {16'hFFFF, 16'h0003, 3'd0, 1'b0, 4'd0,  3'd0},  // R3 prio 0
    {16'hFFFB, 16'h000C, 3'd0, 1'b1, 4'd3,  3'd1},  // R2 one disabled
    {16'h0000, 16'hFFFF, 3'd0, 1'b0, 4'd0,  3'd0},  // R2 all disabled
    {16'hFFFF, 16'h0030, 3'd3, 1'b0, 4'd0,  3'd0},  // R4 not above
    {16'hFFFF, 16'h0100, 3'd3, 1'b1, 4'd8,  3'd4},  // R4 above
    {16'hFFFF, 16'hC000, 3'd6, 1'b1, 4'd14, 3'd7},  // R5 tie at top
    {16'hFFFF, 16'hFFFF, 3'd7, 1'b0, 4'd0,  3'd0},  // R4 level 7
    {16'hFFFF, 16'h1A00, 3'd0, 1'b1, 4'd12, 3'd6},  // R4 mixed
    {16'hFFFF, 16'h0600, 3'd4, 1'b1, 4'd10, 3'd5}   // R4 partial
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input int exp);
    @(negedge clk);
    addr_i = a;
    @(negedge clk);
    chk(tag, int'(rdata_o), exp);
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    src_pulse_i = m;
    @(negedge clk);
    src_pulse_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R11 valid low", int'(irq_valid_o), 0);
    rd_chk("R11 ctrl", A_CTRL, 0);
    rd_chk("R11 level", A_LVL, 0);
    rd_chk("R11 status", A_STAT, 0);
    rd_chk("R11 flags", A_FLAG, 0);

    wr(A_PRI + 5'd0, 16'h1100);
    wr(A_PRI + 5'd1, 16'h3322);
    wr(A_PRI + 5'd2, 16'h5544);
    wr(A_PRI + 5'd3, 16'h7766);
    rd_chk("R3 prio word0", A_PRI, 16'h1100);
    rd_chk("R3 prio word1", A_PRI + 5'd1, 16'h3322);

    for (int k = 0; k < 12; k++) begin
      wr(A_FLAG, 16'hFFFF);
      wr(A_EN, TBL[k][42:27]);
      wr(A_LVL, {13'd0, TBL[k][10:8]});
      base = seen;
      pulse(TBL[k][26:11]);
      idle(4);
      chk($sformatf("R4/R5 case %0d count", k), seen - base, int'(TBL[k][7]));
      if (TBL[k][7]) begin
        chk($sformatf("R6 case %0d vector", k), last_vec, int'(TBL[k][6:3]));
        chk($sformatf("R6 case %0d level", k), last_lvl, int'(TBL[k][2:0]));
      end
    end

    // R1 sticky flag and write-one-to-clear
    wr(A_FLAG, 16'hFFFF);
    wr(A_EN, 16'h0000);
    pulse(16'h0080);
    idle(2);
    rd_chk("R1 sticky", A_FLAG, 16'h0080);
    wr(A_FLAG, 16'h0000);
    rd_chk("R1 zero write ignored", A_FLAG, 16'h0080);
    wr(A_FLAG, 16'h0080);
    rd_chk("R1 cleared", A_FLAG, 16'h0000);

    // R10 set and clear in the same cycle
    @(negedge clk);
    src_pulse_i = 16'h0020;
    we_i = 1'b1; addr_i = A_FLAG; wdata_i = 16'h0020;
    @(negedge clk);
    src_pulse_i = '0; we_i = 1'b0;
    rd_chk("R10 set wins", A_FLAG, 16'h0020);

    // R7 status word
    wr(A_FLAG, 16'hFFFF);
    wr(A_EN, 16'hFFFF);
    wr(A_LVL, 16'h0000);
    pulse(16'h2000);
    idle(4);
    rd_chk("R7 status", A_STAT, 16'h060D);
    rd_chk("R6 level raised", A_LVL, 16'h0006);

    // R8 read-only trap bit
    wr(A_FLAG, 16'hFFFF);
    wr(A_LVL, 16'h000F);
    rd_chk("R8 bit3 not writable", A_LVL, 16'h0007);
    wr(A_LVL, 16'h0000);
    trap_i = 1'b1;
    base = seen;
    pulse(16'h8000);
    idle(4);
    chk("R8 trap blocks", seen - base, 0);
    rd_chk("R8 trap readback", A_LVL, 16'h0008);
    trap_i = 1'b0;
    idle(4);
    chk("R8 release count", seen - base, 1);
    chk("R8 release vector", last_vec, 15);

    // R9 nesting disable
    wr(A_FLAG, 16'hFFFF);
    wr(A_CTRL, 16'h0001);
    rd_chk("R9 ctrl readback", A_CTRL, 1);
    wr(A_LVL, 16'h0002);
    base = seen;
    pulse(16'h8000);
    idle(4);
    chk("R9 held off", seen - base, 0);
    wr(A_LVL, 16'h0000);
    idle(4);
    chk("R9 resumes count", seen - base, 1);
    chk("R9 resumes level", last_lvl, 7);
    wr(A_CTRL, 16'h0000);

    finish_run();
  end
endmodule